// File: doc/BRIEF.md
# Raster Dimension and Clock Monitor

This block watches one video stream and measures its geometry and timing. The stream can be a full timing raster, with blanking beats marked by a low active flag, or a stream that carries only active pixels. Each accepted beat comes with a start-of-frame marker, an end-of-line marker and an active flag. From these the block counts the total and active width of a line, the total and active height of a frame, and the number of stream clocks from one frame start to the next.

A second measurement estimates the stream clock rate. A reference clock of known rate `REF_HZ` opens a gate of exactly `REF_HZ` reference cycles, which is one second. The block counts stream clocks across each gate and reports that count, which is the stream clock rate in Hz. The gate boundary reaches the stream domain through a toggle and a two-flop synchronizer.

All results are read-only words for a register file nearby. Geometry and period words change together, once for each complete frame. A measurement that is switched off by parameter reads as `0x1234abcd`.

Top module: `raster_monitor`

## Requirements
- R1: `horiz_word` holds the total width of the last line in bits 15:0 and the active width in bits 31:16. A line is the run of accepted beats that ends at a beat with `in_eol` high. The active width is the count of beats with `in_active` high in the last line of the frame that had any.
- R2: `vert_word` holds the number of lines in the frame in bits 15:0 and, in bits 31:16, the number of lines that held at least one active beat.
- R3: `active_word` holds the active width in bits 15:0 and the active height in bits 31:16. For a stream that carries only active pixels this gives its full size.
- R4: `period_word` is the number of stream clocks, idle clocks included, between two consecutive accepted start-of-frame beats.
- R5: The geometry and period words and `frame_ok` update together on the clock edge that samples the start-of-frame beat closing a complete frame. At any other time they keep their values.
- R6: The first start-of-frame beat after reset only starts a measurement. Lines seen before it, and the frame it opens until the next frame start, publish nothing. `frame_ok` stays 0 until then.
- R7: A clock with `in_valid` low is not a beat. Its `in_sof`, `in_eol` and `in_active` have no effect on any geometry count, but the clock still counts toward the period.
- R8: `freq_word` is the number of stream clocks in one gate of `REF_HZ` reference clocks. It is first published at the end of the third gate seen after stream reset, when `freq_ok` rises, and is refreshed at the end of every gate after that.
- R9: While `rst_n` is low, every result word and both flags read 0 on the next clock edge.
- R10: With `EN_PERIOD=0` the period word reads `0x1234abcd`. With `EN_FREQ=0` the frequency word reads `0x1234abcd` and `freq_ok` stays 0. With `EN_GEOM=0` the three geometry words read `0x1234abcd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Synchronous active-low reset, stream domain |
| ref_clk | input | 1 | Reference clock of rate `REF_HZ` |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| in_valid | input | 1 | Beat qualifier |
| in_sof | input | 1 | First beat of a frame |
| in_eol | input | 1 | Last beat of a line |
| in_active | input | 1 | Beat lies in the active picture |
| horiz_word | output | 32 | {active width, total width} |
| vert_word | output | 32 | {active height, total height} |
| active_word | output | 32 | {active height, active width} |
| period_word | output | 32 | Stream clocks per frame |
| freq_word | output | 32 | Stream clocks per reference gate |
| frame_ok | output | 1 | A complete frame has been published |
| freq_ok | output | 1 | A frequency result has been published |

## Verification
Several raster shapes are tried, and each one catches a different mistake. An active window set inside the blanking checks that active and total counts are kept apart. A stream of active pixels only checks that equal counts stay equal. A window placed at the end of both line and frame, with idle clocks carrying false markers between lines, shows whether idle clocks are left out of the geometry but still counted in the period. A single active pixel and a single-line frame check the off-by-one limits. The frequency result is checked against a gate whose length in stream clocks is known, and it must not change from one gate to the next.

// File: rtl/rmon_pkg.sv
// Package: shared constants and packing helpers for the raster monitor.
// Assumes result fields are at most 16 bits wide in each half of a word.
package rmon_pkg;

    // Value returned by a measurement switched off at build time.
    localparam logic [31:0] ABSENT_WORD = 32'h1234abcd;

    // Places two 16-bit fields into one result word, lo in bits 15:0.
    function automatic logic [31:0] pack_halves(input logic [15:0] lo,
                                                input logic [15:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rmon_line_meter.sv
// Line meter: counts total and active beats in the current line.
// At each end-of-line beat it latches the total width of that line and,
// if the line held active beats, its active width. A start-of-frame beat
// begins a new line and clears the latched values. Assumes in_valid
// qualifies every marker.
module rmon_line_meter #(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic             eol,
    input  logic             active,
    output logic             eol_tick,
    output logic             line_has_act,
    output logic [DIM_W-1:0] last_tot,
    output logic [DIM_W-1:0] last_act_w
);

    logic [DIM_W-1:0] tot_cnt;
    logic [DIM_W-1:0] act_cnt;
    logic [DIM_W-1:0] base_tot;
    logic [DIM_W-1:0] base_act;
    logic [DIM_W-1:0] line_tot;
    logic [DIM_W-1:0] line_act;

    // Counts as they stand after this beat; a frame start restarts the line.
    always_comb begin
        base_tot     = sof ? '0 : tot_cnt;
        base_act     = sof ? '0 : act_cnt;
        line_tot     = base_tot + DIM_W'(1);
        line_act     = base_act + DIM_W'(active);
        eol_tick     = beat && eol;
        line_has_act = (line_act != '0);
    end

    // Per-line counters and the widths latched at end of line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_cnt    <= '0;
            act_cnt    <= '0;
            last_tot   <= '0;
            last_act_w <= '0;
        end else if (beat) begin
            if (sof) begin
                last_tot   <= '0;
                last_act_w <= '0;
            end
            if (eol) begin
                tot_cnt  <= '0;
                act_cnt  <= '0;
                last_tot <= line_tot;
                if (line_act != '0) begin
                    last_act_w <= line_act;
                end
            end else begin
                tot_cnt <= line_tot;
                act_cnt <= line_act;
            end
        end
    end

    // R1: a line never has more active beats than beats.
    a_r1_act_within_total: assert property (@(posedge clk) disable iff (!rst_n)
        eol_tick |-> (line_act <= line_tot));

    // R7: a clock without a beat leaves the line counters alone.
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> ($stable(tot_cnt) && $stable(act_cnt)));

endmodule

// File: rtl/rmon_frame_meter.sv
// Frame meter: counts lines, active lines and stream clocks for each frame,
// then publishes all geometry and the period together at the start-of-frame
// beat that closes a complete frame. The first frame start after reset only
// arms the meter. Assumes the line meter supplies the latched widths.
module rmon_frame_meter #(
    parameter int DIM_W = 16,
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic             eol_tick,
    input  logic             line_has_act,
    input  logic [DIM_W-1:0] last_tot,
    input  logic [DIM_W-1:0] last_act_w,
    output logic [DIM_W-1:0] h_tot_q,
    output logic [DIM_W-1:0] h_act_q,
    output logic [DIM_W-1:0] v_tot_q,
    output logic [DIM_W-1:0] v_act_q,
    output logic [PER_W-1:0] period_q,
    output logic             frame_ok
);

    logic             frame_start;
    logic             armed;
    logic [PER_W-1:0] clk_cnt;
    logic [DIM_W-1:0] lines;
    logic [DIM_W-1:0] act_lines;
    logic [DIM_W-1:0] base_lines;
    logic [DIM_W-1:0] base_act_lines;

    // Frame start detection and the counts a new frame starts from.
    always_comb begin
        frame_start    = beat && sof;
        base_lines     = frame_start ? '0 : lines;
        base_act_lines = frame_start ? '0 : act_lines;
    end

    // Stream clocks since the last frame start, idle clocks included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_cnt <= '0;
        end else if (frame_start) begin
            clk_cnt <= PER_W'(1);
        end else begin
            clk_cnt <= clk_cnt + PER_W'(1);
        end
    end

    // Line and active-line counts within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines     <= '0;
            act_lines <= '0;
        end else if (eol_tick) begin
            lines     <= base_lines + DIM_W'(1);
            act_lines <= base_act_lines + DIM_W'(line_has_act);
        end else if (frame_start) begin
            lines     <= '0;
            act_lines <= '0;
        end
    end

    // Publication of the closed frame, all words in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            frame_ok <= 1'b0;
            h_tot_q  <= '0;
            h_act_q  <= '0;
            v_tot_q  <= '0;
            v_act_q  <= '0;
            period_q <= '0;
        end else if (frame_start) begin
            armed <= 1'b1;
            if (armed) begin
                frame_ok <= 1'b1;
                h_tot_q  <= last_tot;
                h_act_q  <= last_act_w;
                v_tot_q  <= lines;
                v_act_q  <= act_lines;
                period_q <= clk_cnt;
            end
        end
    end

    // R2: active height never exceeds total height once published.
    a_r2_act_lines_bound: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> (v_act_q <= v_tot_q));

    // R5: results change only on a frame start beat.
    a_r5_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(period_q) && $stable(v_tot_q) && $stable(h_tot_q)));

    // R5: the publication flag never drops outside reset.
    a_r5_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> frame_ok);

    // R6: nothing is published before the meter has been armed.
    a_r6_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !frame_ok);

endmodule

// File: rtl/rmon_freq_meter.sv
// Frequency meter: the reference domain toggles a flag at the end of each
// gate of REF_HZ reference cycles. The stream domain synchronizes the toggle
// and, on each edge of it, takes a snapshot of a free-running stream clock
// counter. The difference between two snapshots is the count for one gate.
// The first edge after a stream reset may be spurious, so a result is only
// published from the third edge on. Assumes REF_HZ >= 2.
module rmon_freq_meter #(
    parameter int REF_HZ = 100_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    output logic [CNT_W-1:0] freq_q,
    output logic             freq_ok
);

    localparam int GATE_W = $clog2(REF_HZ);
    localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(REF_HZ - 1);

    logic [GATE_W-1:0] gate_cnt;
    logic              gate_tog;
    logic              sync_meta;
    logic              sync_mid;
    logic              sync_old;
    logic              gate_edge;
    logic [CNT_W-1:0]  run_cnt;
    logic [CNT_W-1:0]  snap;
    logic [1:0]        edges_seen;

    // Reference domain: gate counter and end-of-gate toggle.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            gate_cnt <= '0;
            gate_tog <= 1'b0;
        end else if (gate_cnt == GATE_LAST) begin
            gate_cnt <= '0;
            gate_tog <= ~gate_tog;
        end else begin
            gate_cnt <= gate_cnt + GATE_W'(1);
        end
    end

    // Stream domain: two-flop synchronizer plus a history flop for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_meta <= 1'b0;
            sync_mid  <= 1'b0;
            sync_old  <= 1'b0;
        end else begin
            sync_meta <= gate_tog;
            sync_mid  <= sync_meta;
            sync_old  <= sync_mid;
        end
    end

    // Edge of the synchronized toggle marks the end of a gate.
    always_comb begin
        gate_edge = sync_mid ^ sync_old;
    end

    // Free-running stream clock counter, snapshots and published difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            snap       <= '0;
            edges_seen <= '0;
            freq_q     <= '0;
            freq_ok    <= 1'b0;
        end else begin
            run_cnt <= run_cnt + CNT_W'(1);
            if (gate_edge) begin
                snap <= run_cnt;
                if (edges_seen == 2'd2) begin
                    freq_q  <= run_cnt - snap;
                    freq_ok <= 1'b1;
                end else begin
                    edges_seen <= edges_seen + 2'd1;
                end
            end
        end
    end

    // R8: the gate counter stays inside one gate.
    a_r8_gate_bound: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        gate_cnt <= GATE_LAST);

    // R8: the frequency result is only refreshed at a gate edge.
    a_r8_update_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_edge |=> $stable(freq_q));

    // R8: once valid, the frequency flag stays up until reset.
    a_r8_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        freq_ok |=> freq_ok);

endmodule

// File: rtl/raster_monitor.sv
// Raster dimension and clock monitor top. Joins the line, frame and
// frequency meters and packs their results into read-only words. A
// measurement switched off by parameter reads as the absent pattern.
// Assumes DIM_W <= 16 and inputs synchronous to clk.
module raster_monitor #(
    parameter int DIM_W     = 16,
    parameter int REF_HZ    = 100_000_000,
    parameter bit EN_GEOM   = 1'b1,
    parameter bit EN_PERIOD = 1'b1,
    parameter bit EN_FREQ   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_clk,
    input  logic        ref_rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eol,
    input  logic        in_active,
    output logic [31:0] horiz_word,
    output logic [31:0] vert_word,
    output logic [31:0] active_word,
    output logic [31:0] period_word,
    output logic [31:0] freq_word,
    output logic        frame_ok,
    output logic        freq_ok
);
    import rmon_pkg::*;

    localparam int WORD_W = 32;

    logic             eol_tick;
    logic             line_has_act;
    logic [DIM_W-1:0] last_tot;
    logic [DIM_W-1:0] last_act_w;
    logic [DIM_W-1:0] h_tot_q;
    logic [DIM_W-1:0] h_act_q;
    logic [DIM_W-1:0] v_tot_q;
    logic [DIM_W-1:0] v_act_q;
    logic [WORD_W-1:0] period_q;

    rmon_line_meter #(.DIM_W(DIM_W)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (in_valid),
        .sof          (in_sof),
        .eol          (in_eol),
        .active       (in_active),
        .eol_tick     (eol_tick),
        .line_has_act (line_has_act),
        .last_tot     (last_tot),
        .last_act_w   (last_act_w)
    );

    rmon_frame_meter #(.DIM_W(DIM_W), .PER_W(WORD_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (in_valid),
        .sof          (in_sof),
        .eol_tick     (eol_tick),
        .line_has_act (line_has_act),
        .last_tot     (last_tot),
        .last_act_w   (last_act_w),
        .h_tot_q      (h_tot_q),
        .h_act_q      (h_act_q),
        .v_tot_q      (v_tot_q),
        .v_act_q      (v_act_q),
        .period_q     (period_q),
        .frame_ok     (frame_ok)
    );

    // Geometry words, or the absent pattern when switched off.
    if (EN_GEOM) begin : g_geom
        assign horiz_word  = pack_halves(16'(h_tot_q), 16'(h_act_q));
        assign vert_word   = pack_halves(16'(v_tot_q), 16'(v_act_q));
        assign active_word = pack_halves(16'(h_act_q), 16'(v_act_q));
    end else begin : g_no_geom
        assign horiz_word  = ABSENT_WORD;
        assign vert_word   = ABSENT_WORD;
        assign active_word = ABSENT_WORD;
    end

    // Period word, or the absent pattern when switched off.
    if (EN_PERIOD) begin : g_period
        assign period_word = period_q;
    end else begin : g_no_period
        assign period_word = ABSENT_WORD;
    end

    // Frequency meter, built only when requested.
    if (EN_FREQ) begin : g_freq
        rmon_freq_meter #(.REF_HZ(REF_HZ), .CNT_W(WORD_W)) u_freq (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_clk   (ref_clk),
            .ref_rst_n (ref_rst_n),
            .freq_q    (freq_word),
            .freq_ok   (freq_ok)
        );
    end else begin : g_no_freq
        assign freq_word = ABSENT_WORD;
        assign freq_ok   = 1'b0;
    end

    // R10: a disabled frequency meter never reports a result.
    a_r10_freq_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !EN_FREQ |-> (!freq_ok && freq_word == ABSENT_WORD));

    // R9: the clock after reset leaves no published frame.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !frame_ok);

endmodule

// File: tb/raster_monitor_test.sv
module raster_monitor_test;

    localparam int REF_HZ_TB = 50;
    localparam int CLK_NS = 4;
    localparam int REF_NS = 10;
    localparam int GATE_CLKS = REF_HZ_TB * REF_NS / CLK_NS;
    localparam logic [31:0] ABSENT = 32'h1234abcd;

    typedef struct packed {
        logic [15:0] h_tot;
        logic [15:0] h_act;
        logic [15:0] h_off;
        logic [15:0] v_tot;
        logic [15:0] v_act;
        logic [15:0] v_off;
        logic [15:0] gap;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd12, 16'd8,  16'd2,  16'd6, 16'd4, 16'd1, 16'd0},
        '{16'd10, 16'd10, 16'd0,  16'd5, 16'd5, 16'd0, 16'd0},
        '{16'd9,  16'd5,  16'd4,  16'd7, 16'd2, 16'd5, 16'd3},
        '{16'd16, 16'd1,  16'd0,  16'd3, 16'd1, 16'd2, 16'd1},
        '{16'd7,  16'd7,  16'd0,  16'd1, 16'd1, 16'd0, 16'd2},
        '{16'd20, 16'd3,  16'd17, 16'd4, 16'd4, 16'd0, 16'd0}
    };

    logic clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic in_eol = 1'b0;
    logic in_active = 1'b0;
    logic [31:0] horiz_word, vert_word, active_word, period_word, freq_word;
    logic frame_ok, freq_ok;
    logic [31:0] off_h, off_v, off_a, off_p, off_f;
    logic off_fok, off_ffok;

    int total = 0;
    int bad = 0;

    always #(CLK_NS / 2) clk = ~clk;
    always #(REF_NS / 2) ref_clk = ~ref_clk;

    raster_monitor #(.REF_HZ(REF_HZ_TB)) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_active(in_active),
        .horiz_word(horiz_word), .vert_word(vert_word), .active_word(active_word),
        .period_word(period_word), .freq_word(freq_word),
        .frame_ok(frame_ok), .freq_ok(freq_ok)
    );

    raster_monitor #(.REF_HZ(REF_HZ_TB), .EN_PERIOD(1'b0), .EN_FREQ(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_active(in_active),
        .horiz_word(off_h), .vert_word(off_v), .active_word(off_a),
        .period_word(off_p), .freq_word(off_f),
        .frame_ok(off_fok), .freq_ok(off_ffok)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one frame; when chk is set, checks the results of the previous
    // frame right after this frame's start beat and again at its end.
    task automatic send_frame(input vec_t v, input bit chk, input int idx);
        logic [31:0] exp_period;
        exp_period = 32'(v.v_tot) * (32'(v.h_tot) + 32'(v.gap));
        for (int y = 0; y < int'(v.v_tot); y++) begin
            for (int x = 0; x < int'(v.h_tot); x++) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_sof    = (x == 0 && y == 0);
                in_eol    = (x == int'(v.h_tot) - 1);
                in_active = (x >= int'(v.h_off)) && (x < int'(v.h_off + v.h_act)) &&
                            (y >= int'(v.v_off)) && (y < int'(v.v_off + v.v_act));
                if (chk && x == 0 && y == 0) begin
                    @(posedge clk);
                    #1;
                    $display("vector %0d", idx);
                    check_eq("R1", "horiz", horiz_word, {v.h_act, v.h_tot});
                    check_eq("R2", "vert", vert_word, {v.v_act, v.v_tot});
                    check_eq("R3", "active", active_word, {v.v_act, v.h_act});
                    check_eq("R4", "period", period_word, exp_period);
                    check_eq("R5", "frame_ok", 32'(frame_ok), 32'd1);
                    if (v.gap != 0)
                        check_eq("R7", "idle markers ignored", vert_word, {v.v_act, v.v_tot});
                end
            end
            for (int g = 0; g < int'(v.gap); g++) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_sof    = 1'b1;
                in_eol    = 1'b1;
                in_active = 1'b1;
            end
        end
        if (chk) begin
            check_eq("R5", "period held within frame", period_word, exp_period);
            check_eq("R5", "horiz held within frame", horiz_word, {v.h_act, v.h_tot});
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] f1;
        repeat (5) @(posedge clk);
        #1;
        check_eq("R9", "horiz at reset", horiz_word, 32'd0);
        check_eq("R9", "period at reset", period_word, 32'd0);
        check_eq("R9", "flags at reset", {30'd0, frame_ok, freq_ok}, 32'd0);
        check_eq("R10", "period off", off_p, ABSENT);
        check_eq("R10", "freq off", off_f, ABSENT);
        @(negedge clk);
        rst_n = 1'b1;
        ref_rst_n = 1'b1;

        // R6: partial line before the first frame start, then the first start.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eol = (k == 4); in_active = (k > 1);
        end
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b0; in_active = 1'b0;
        @(posedge clk);
        #1;
        check_eq("R6", "frame_ok after first start", 32'(frame_ok), 32'd0);
        check_eq("R6", "vert after first start", vert_word, 32'd0);

        // Table of raster shapes.
        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i], 1'b0, i);
            send_frame(VECS[i], 1'b1, i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_active = 1'b0;

        // R8: frequency against a known gate.
        repeat (1000) @(posedge clk);
        #1;
        check_eq("R8", "freq_ok", 32'(freq_ok), 32'd1);
        total++;
        if (freq_word + 1 < 32'(GATE_CLKS) || freq_word > 32'(GATE_CLKS) + 1) begin
            bad++;
            $display("FAIL R8 freq: actual=%0d expected=%0d", freq_word, GATE_CLKS);
        end
        f1 = freq_word;
        repeat (2 * GATE_CLKS) @(posedge clk);
        #1;
        check_eq("R8", "freq steady", freq_word, f1);
        check_eq("R10", "freq off after run", off_f, ABSENT);
        check_eq("R10", "freq_ok off", 32'(off_ffok), 32'd0);
        check_eq("R10", "period off after run", off_p, ABSENT);

        // R9: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_eq("R9", "horiz after reset", horiz_word, 32'd0);
        check_eq("R9", "vert after reset", vert_word, 32'd0);
        check_eq("R9", "freq after reset", freq_word, 32'd0);
        check_eq("R9", "flags after reset", {30'd0, frame_ok, freq_ok}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule